// File: doc/BRIEF.md
# Relocatable ROM Mapping Decoder

This block decides, for every CPU memory cycle, which device answers: a page of cartridge ROM, the main RAM, or a page of memory-mapped control registers. The 64 KB CPU space is split into four 16 KB quadrants. A lower ROM window can be placed in any quadrant. An upper ROM window always sits in the top quadrant, and a 7-bit page register picks which of up to 128 physical ROM pages appears there. When the register page is enabled, it occupies the second quadrant (addresses 0x4000 to 0x7FFF).

Each ROM window can be switched off by its own bit from the mode register, and an external ROM-disable pin switches both off. A read from a window that is switched off falls through to RAM. Writes never go to ROM. A write to an address mapped as ROM lands in the RAM underneath it, wherever that ROM has been placed. The register page is kept apart from this write-through in both directions. A write inside the register window reaches only the registers, and a write into a ROM window never reaches register space.

All inputs are sampled on a rising clock edge, and the selects and page number are registered outputs. A change to a page register or a disable bit therefore applies to the whole of the next cycle, and the decode never mixes old and new settings.

Top module: `reloc_rom_decoder`

## Requirements
- R1: While rst_n is low, and after it is released until the first sampled access, rom_sel, ram_sel and reg_sel are 0 and rom_page is 0.
- R2: At most one of rom_sel, ram_sel, reg_sel is 1 in any cycle. All three are 0 after a cycle in which cpu_rd and cpu_wr were both 0 or both 1.
- R3: A read (cpu_rd=1, cpu_wr=0) whose address bits [15:14] equal lo_win_quad, with lo_rom_off=0 and ext_rom_off=0, gives rom_sel=1 and rom_page=lo_rom_page.
- R4: A read with address bits [15:14]=3, with hi_rom_off=0 and ext_rom_off=0, and with the lower window not enabled in quadrant 3, gives rom_sel=1 and rom_page=hi_rom_page, for any page value 0 to 127. rom_page is 0 whenever rom_sel is 0.
- R5: lo_rom_off=1 disables the lower window, and hi_rom_off=1 disables the upper window, in whichever quadrant each window is mapped. A read there then gives ram_sel=1.
- R6: ext_rom_off=1 disables both ROM windows. Any access then gives rom_sel=0.
- R7: A write (cpu_wr=1, cpu_rd=0) outside the register window gives ram_sel=1, including writes to addresses currently mapped as ROM, and never gives rom_sel.
- R8: With regpg_en=1, any read or write with address bits [15:14]=1 gives reg_sel=1 only. This holds even when a ROM window is mapped to that quadrant, so such a write reaches neither RAM nor ROM. With regpg_en=0 that quadrant decodes like any other.
- R9: When the lower window is mapped to quadrant 3 and both windows are enabled, a read there gives the lower window's page.
- R10: The outputs in the cycle after a rising edge reflect only the inputs sampled at that edge. A setting change applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| lo_win_quad | input | 2 | Quadrant that holds the lower ROM window |
| lo_rom_page | input | 7 | Physical page shown in the lower window |
| hi_rom_page | input | 7 | Physical page shown in the upper window (0 to 127) |
| lo_rom_off | input | 1 | Mode-register bit that disables the lower ROM window |
| hi_rom_off | input | 1 | Mode-register bit that disables the upper ROM window |
| ext_rom_off | input | 1 | External pin that disables all ROM |
| regpg_en | input | 1 | Maps the register page into quadrant 1 |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | RAM chip select |
| reg_sel | output | 1 | Register-page select |
| rom_page | output | 7 | Physical ROM page for the current access |

## Verification
Reads are tried with the lower window moved through all four quadrants and with the upper page swept to both ends of its range. These cases separate a correct window match from a hard-wired one, and a full page path from a truncated one. Writes are aimed at every ROM window and at the register window with ROM overlapping it. These cases show that write-through reaches RAM, and that it is blocked toward the register page in both directions. Each disable source is toggled on its own, and random mixes of all settings, including the overlap in quadrant 3 and illegal double strobes, check the priority order against a bench model.

// File: rtl/rmd_pkg.sv
package rmd_pkg;
    parameter int ADDR_W   = 16;
    parameter int QUAD_W   = 2;
    parameter int PAGE_W   = 7;
    parameter int N_WIN    = 2;
    parameter int REG_QUAD = 1;
    parameter int HI_QUAD  = 3;

    localparam int WIN_LO = 0;
    localparam int WIN_HI = 1;

    typedef struct packed {
        logic              rom;
        logic              ram;
        logic              regp;
        logic [PAGE_W-1:0] page;
    } sel_t;

    localparam sel_t SEL_IDLE = '{rom: 1'b0, ram: 1'b0, regp: 1'b0, page: '0};
endpackage

// File: rtl/rmd_window_hit.sv
module rmd_window_hit
    import rmd_pkg::*;
#(
    parameter int QW = QUAD_W
) (
    input  logic [QW-1:0] addr_quad,
    input  logic [QW-1:0] win_quad,
    input  logic          win_off,
    input  logic          all_off,
    output logic          mapped,
    output logic          live
);
    // mapped: window placed on the addressed quadrant; live: also enabled
    always_comb begin
        mapped = (addr_quad == win_quad);
        live   = mapped && !win_off && !all_off;
    end
endmodule

// File: rtl/rmd_select.sv
module rmd_select
    import rmd_pkg::*;
(
    input  logic              rd,
    input  logic              wr,
    input  logic              regpg_en,
    input  logic [QUAD_W-1:0] addr_quad,
    input  logic [N_WIN-1:0]  win_live,
    input  logic [PAGE_W-1:0] lo_page,
    input  logic [PAGE_W-1:0] hi_page,
    output sel_t              sel
);
    localparam logic [QUAD_W-1:0] REGQ = QUAD_W'(REG_QUAD);

    logic access;
    logic in_regwin;

    always_comb begin
        access    = rd ^ wr;
        in_regwin = regpg_en && (addr_quad == REGQ);
        sel       = SEL_IDLE;
        if (!access) begin
            sel = SEL_IDLE;
        end else if (in_regwin) begin
            // register page shadows everything, no write-through either way
            sel.regp = 1'b1;
        end else if (wr) begin
            // write-through: ROM-mapped or not, the RAM takes the write
            sel.ram = 1'b1;
        end else if (win_live[WIN_LO]) begin
            sel.rom  = 1'b1;
            sel.page = lo_page;
        end else if (win_live[WIN_HI]) begin
            sel.rom  = 1'b1;
            sel.page = hi_page;
        end else begin
            sel.ram = 1'b1;
        end
    end
endmodule

// File: rtl/reloc_rom_decoder.sv
module reloc_rom_decoder
    import rmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [1:0]        lo_win_quad,
    input  logic [6:0]        lo_rom_page,
    input  logic [6:0]        hi_rom_page,
    input  logic              lo_rom_off,
    input  logic              hi_rom_off,
    input  logic              ext_rom_off,
    input  logic              regpg_en,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              reg_sel,
    output logic [6:0]        rom_page
);
    localparam logic [QUAD_W-1:0] HIQ = QUAD_W'(HI_QUAD);

    logic [QUAD_W-1:0] addr_quad;
    logic [QUAD_W-1:0] win_quad [N_WIN];
    logic [N_WIN-1:0]  win_off;
    logic [N_WIN-1:0]  win_mapped;
    logic [N_WIN-1:0]  win_live;
    sel_t              sel_n;
    sel_t              state_d;
    sel_t              state_q;

    always_comb begin
        addr_quad        = cpu_addr[ADDR_W-1 -: QUAD_W];
        win_quad[WIN_LO] = lo_win_quad;
        win_quad[WIN_HI] = HIQ;
        win_off          = '0;
        win_off[WIN_LO]  = lo_rom_off;
        win_off[WIN_HI]  = hi_rom_off;
    end

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        rmd_window_hit #(.QW(QUAD_W)) u_hit (
            .addr_quad (addr_quad),
            .win_quad  (win_quad[w]),
            .win_off   (win_off[w]),
            .all_off   (ext_rom_off),
            .mapped    (win_mapped[w]),
            .live      (win_live[w])
        );
    end

    rmd_select u_sel (
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .regpg_en  (regpg_en),
        .addr_quad (addr_quad),
        .win_live  (win_live),
        .lo_page   (lo_rom_page),
        .hi_page   (hi_rom_page),
        .sel       (sel_n)
    );

    always_comb begin
        state_d = sel_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rom_sel  = state_q.rom;
        ram_sel  = state_q.ram;
        reg_sel  = state_q.regp;
        rom_page = state_q.page;
    end

    logic unused_mapped;
    always_comb unused_mapped = ^win_mapped;
endmodule

// File: rtl/rmd_checker.sv
module rmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [1:0]  lo_win_quad,
    input logic [6:0]  lo_rom_page,
    input logic [6:0]  hi_rom_page,
    input logic        lo_rom_off,
    input logic        hi_rom_off,
    input logic        ext_rom_off,
    input logic        regpg_en,
    input logic        rom_sel,
    input logic        ram_sel,
    input logic        reg_sel,
    input logic [6:0]  rom_page
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel, reg_sel})); // R2
    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd == cpu_wr) |=> (!rom_sel && !ram_sel && !reg_sel)); // R2
    AST_PAGE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel |-> (rom_page == 7'd0)); // R4
    AST_EXT_OFF_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rom_off |=> !rom_sel); // R6
    AST_WR_NEVER_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd) |=> !rom_sel); // R7
    AST_REG_OWNS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (regpg_en && cpu_addr[15:14] == 2'd1 && (cpu_rd ^ cpu_wr)) |=> reg_sel); // R8
    AST_HI_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_addr[15:14] == 2'd3 && !hi_rom_off && !ext_rom_off
         && !(lo_win_quad == 2'd3 && !lo_rom_off))
        |=> (rom_sel && rom_page == $past(hi_rom_page))); // R4
endmodule

bind reloc_rom_decoder rmd_checker u_rmd_checker (.*);

// File: tb/reloc_rom_decoder_bench.sv
module reloc_rom_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [1:0]  lo_win_quad = '0;
    logic [6:0]  lo_rom_page = '0, hi_rom_page = '0;
    logic        lo_rom_off = 1'b0, hi_rom_off = 1'b0, ext_rom_off = 1'b0, regpg_en = 1'b0;
    logic        rom_sel, ram_sel, reg_sel;
    logic [6:0]  rom_page;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    reloc_rom_decoder u_reloc_rom_decoder (.*);

    // expected {rom, ram, reg, page}
    function automatic logic [9:0] model();
        logic [1:0] q;
        logic lo_on, hi_on;
        q     = cpu_addr[15:14];
        lo_on = (q == lo_win_quad) && !lo_rom_off && !ext_rom_off;
        hi_on = (q == 2'd3) && !hi_rom_off && !ext_rom_off;
        if (cpu_rd == cpu_wr)              return 10'd0;
        if (regpg_en && q == 2'd1)         return {3'b001, 7'd0};
        if (cpu_wr)                        return {3'b010, 7'd0};
        if (lo_on)                         return {3'b100, lo_rom_page};
        if (hi_on)                         return {3'b100, hi_rom_page};
        return {3'b010, 7'd0};
    endfunction

    task automatic check(input logic [9:0] exp, input string req);
        logic [9:0] act;
        act = {rom_sel, ram_sel, reg_sel, rom_page};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual rom=%b ram=%b reg=%b page=%0d expected rom=%b ram=%b reg=%b page=%0d",
                     req, act[9], act[8], act[7], act[6:0], exp[9], exp[8], exp[7], exp[6:0]);
        end
    endtask

    // inputs already set at negedge; step one edge then compare at the next negedge
    task automatic step(input string req);
        logic [9:0] exp;
        exp = model();
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic acc(input logic [15:0] a, input logic r, input logic w, input string req);
        cpu_addr = a; cpu_rd = r; cpu_wr = w;
        step(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(10'd0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(10'd0, "R1 after release");

        // R3: lower window through every quadrant
        lo_rom_page = 7'd5;
        for (int q = 0; q < 4; q++) begin
            lo_win_quad = q[1:0];
            acc({q[1:0], 14'h0123}, 1'b1, 1'b0, "R3 lower window read");
        end
        // R4: upper page extremes
        lo_win_quad = 2'd0;
        hi_rom_page = 7'd0;   acc(16'hC000, 1'b1, 1'b0, "R4 upper page 0");
        hi_rom_page = 7'd127; acc(16'hFFFF, 1'b1, 1'b0, "R4 upper page 127");
        acc(16'h8000, 1'b1, 1'b0, "R4 plain RAM read page 0");
        // R9 overlap
        lo_win_quad = 2'd3;   acc(16'hD000, 1'b1, 1'b0, "R9 lower wins in quadrant 3");
        lo_rom_off = 1'b1;    acc(16'hD000, 1'b1, 1'b0, "R5 lower off shows upper");
        hi_rom_off = 1'b1;    acc(16'hD000, 1'b1, 1'b0, "R5 both off read falls to RAM");
        lo_win_quad = 2'd2;   acc(16'h9000, 1'b1, 1'b0, "R5 lower off when relocated");
        lo_rom_off = 1'b0; hi_rom_off = 1'b0;
        // R6
        ext_rom_off = 1'b1;
        acc(16'h9000, 1'b1, 1'b0, "R6 ext off lower");
        acc(16'hE000, 1'b1, 1'b0, "R6 ext off upper");
        ext_rom_off = 1'b0;
        // R7 write-through
        acc(16'h9000, 1'b0, 1'b1, "R7 write to lower ROM goes RAM");
        acc(16'hF000, 1'b0, 1'b1, "R7 write to upper ROM goes RAM");
        // R8 register page
        regpg_en = 1'b1; lo_win_quad = 2'd1;
        acc(16'h4800, 1'b1, 1'b0, "R8 reg read over ROM");
        acc(16'h7FFF, 1'b0, 1'b1, "R8 reg write not RAM");
        acc(16'hC000, 1'b0, 1'b1, "R8 ROM write not register");
        regpg_en = 1'b0;
        acc(16'h4800, 1'b1, 1'b0, "R8 disabled quadrant decodes ROM");
        // R2 idle and double strobe
        acc(16'hC000, 1'b0, 1'b0, "R2 idle");
        acc(16'hC000, 1'b1, 1'b1, "R2 double strobe");
        // R10: page change applies next cycle
        lo_win_quad = 2'd0; hi_rom_page = 7'd9;
        acc(16'hC000, 1'b1, 1'b0, "R10 first page");
        hi_rom_page = 7'd77;
        acc(16'hC000, 1'b1, 1'b0, "R10 new page next cycle");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            cpu_addr    = 16'($urandom);
            cpu_rd      = ($urandom % 4) != 0;
            cpu_wr      = ($urandom % 3) == 0;
            lo_win_quad = 2'($urandom);
            lo_rom_page = 7'($urandom);
            hi_rom_page = 7'($urandom);
            lo_rom_off  = ($urandom % 4) == 0;
            hi_rom_off  = ($urandom % 4) == 0;
            ext_rom_off = ($urandom % 8) == 0;
            regpg_en    = ($urandom % 2) == 0;
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        rst_n = 1'b0;
        @(negedge clk);
        check(10'd0, "R1 reset again");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule